// File: doc/BRIEF.md
# Third-Order Cascaded Sigma-Delta Modulator

This block turns a fixed fractional word into a stream of small signed integer corrections. Over time these corrections average to the fraction divided by 2^W. Three first-order accumulators are chained. Each stage adds the wrapped sum of the stage before it into its own register, and its carry-out acts as a one-bit quantizer. The three carries are then combined through first- and second-difference networks. The quantization error of the last stage reaches the output shaped by (1 − z⁻¹)³, which pushes the noise towards high frequency. The output takes eight levels, from −3 to +4.

The block runs on the reference clock and is fully digital. A divider-control path adds the output to its integer ratio on every reference cycle. When the enable is low, all state is frozen and the output is forced to zero, so the path sees a plain integer ratio.

Top module: `mash111_mod`

## Requirements
- R1: While rst_ni is low, and on the first clock edge after it is released, all accumulators and carry delay registers are zero and y_o is 0.
- R2: Stage 1 computes s1 = acc1 + frac_i modulo 2^W. Its carry c1 is bit W of the unwrapped sum, and acc1 takes the value s1.
- R3: y_o is a 4-bit two's-complement value that always lies in the range −3 to +4.
- R4: On every enabled edge, y_o takes the value c1[n] + c2[n] − c2[n−1] + c3[n] − 2·c3[n−1] + c3[n−2]. The delayed carries are those of earlier enabled cycles, and they are zero after reset.
- R5: Stage 2 adds the wrapped sum s1 of stage 1 into acc2. Stage 3 adds the wrapped sum s2 of stage 2 into acc3. Each stage uses the sum from the same cycle, and each carry is bit W of its stage's sum.
- R6: While en_i is low, the accumulators and carry delays hold their values, and y_o is 0 after the next edge. When en_i is set again, the sequence continues from the held state.
- R7: With frac_i = 0 from reset, y_o stays 0.
- R8: Over 2^W consecutive enabled cycles from reset with a constant frac_i = x, the sum of y_o lies between x−1 and x+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enables modulation; when low, state is frozen and the output is zero |
| frac_i | input | W | Unsigned fractional input word |
| y_o | output | 4 | Signed correction, −3 to +4 |

## Verification
A corrupted accumulator or a mis-wired cascade changes the carries. This appears at y_o on the very next enabled edge as a value that differs from the cycle-exact reference model. A wrong carry delay shows up one or two enabled cycles later, through the difference terms. A small bias in the arithmetic may leave each single output in range, but it moves the sum over a full 2^W-cycle window outside its bound. Holding the state while disabled is checked by resuming the model with no gap.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int unsigned NUM_STAGES = 3;
  localparam int unsigned OUT_W      = 4;
  typedef logic signed [OUT_W-1:0] mash_out_t;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum_w;

  assign sum_w   = {1'b0, acc_q} + {1'b0, in_i};
  assign res_o   = sum_w[W-1:0];
  assign carry_o = sum_w[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_w[W-1:0];
  end

  // R6: frozen while disabled
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
endmodule

// File: rtl/mash_noise_cancel.sv
module mash_noise_cancel
  import mash_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [NUM_STAGES-1:0] c_i,
  output mash_out_t             y_o
);
  logic      c2_d1_q, c3_d1_q, c3_d2_q;
  mash_out_t y_next;

  // c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
  always_comb begin
    y_next = $signed({3'b000, c_i[0]})
           + $signed({3'b000, c_i[1]})
           - $signed({3'b000, c2_d1_q})
           + $signed({3'b000, c_i[2]})
           - $signed({2'b00, c3_d1_q, 1'b0})
           + $signed({3'b000, c3_d2_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_d1_q <= 1'b0;
      c3_d1_q <= 1'b0;
      c3_d2_q <= 1'b0;
      y_o     <= '0;
    end else if (en_i) begin
      c2_d1_q <= c_i[1];
      c3_d1_q <= c_i[2];
      c3_d2_q <= c3_d1_q;
      y_o     <= y_next;
    end else begin
      y_o     <= '0;
    end
  end

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_o >= -4'sd3) && (y_o <= 4'sd4));
  p_zero_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (y_o == 4'sd0));
  p_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (c3_d1_q == $past(c_i[2])) && (c2_d1_q == $past(c_i[1])));
  p_delay_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(c3_d2_q) && $stable(c3_d1_q));
endmodule

// File: rtl/mash111_mod.sv
module mash111_mod
  import mash_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [W-1:0]    frac_i,
  output logic [OUT_W-1:0] y_o
);
  logic [W-1:0]          chain [0:NUM_STAGES];
  logic [NUM_STAGES-1:0] carry;
  mash_out_t             y_int;

  assign chain[0] = frac_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    mash_acc_stage #(.W(W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .in_i    (chain[k]),
      .res_o   (chain[k+1]),
      .carry_o (carry[k])
    );
  end

  mash_noise_cancel u_nc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .c_i    (carry),
    .y_o    (y_int)
  );

  assign y_o = y_int;
endmodule

// File: tb/mash111_mod_bench.sv
`timescale 1ns/1ps
module mash111_mod_bench;
  localparam int unsigned BW = 10;
  localparam int unsigned N  = 1 << BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [BW-1:0] frac = '0;
  logic [3:0]    y;

  int n_chk = 0;
  int n_err = 0;

  // reference state
  logic [BW-1:0] m_a1, m_a2, m_a3;
  logic          m_c2d, m_c3d, m_c3dd;
  int            m_exp;

  always #2.5 clk = ~clk;

  mash111_mod #(.W(BW)) u_mash111_mod (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .frac_i(frac), .y_o(y)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_a1 = '0; m_a2 = '0; m_a3 = '0;
    m_c2d = 1'b0; m_c3d = 1'b0; m_c3dd = 1'b0;
    m_exp = 0;
  endtask

  task automatic model_step(input logic [BW-1:0] x, input logic e);
    logic [BW:0] s1, s2, s3;
    if (!e) begin
      m_exp = 0;
      return;
    end
    s1 = {1'b0, m_a1} + {1'b0, x};
    s2 = {1'b0, m_a2} + {1'b0, s1[BW-1:0]};
    s3 = {1'b0, m_a3} + {1'b0, s2[BW-1:0]};
    m_exp = int'(s1[BW]) + int'(s2[BW]) - int'(m_c2d)
          + int'(s3[BW]) - 2*int'(m_c3d) + int'(m_c3dd);
    m_a1 = s1[BW-1:0]; m_a2 = s2[BW-1:0]; m_a3 = s3[BW-1:0];
    m_c2d = s2[BW]; m_c3dd = m_c3d; m_c3d = s3[BW];
  endtask

  // drive at negedge, sample at next negedge
  task automatic step(input logic [BW-1:0] x, input logic e, input string tag);
    frac = x; en = e;
    model_step(x, e);
    @(posedge clk); @(negedge clk);
    check(tag, int'($signed(y)), m_exp);
    if ($signed(y) < -3 || $signed(y) > 4) check("R3 range", int'($signed(y)), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    model_clear();
    @(negedge clk);
    check("R1 y in reset", int'($signed(y)), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int sum;
    logic [BW-1:0] xv;
    void'($urandom(32'd1234));
    model_clear();
    @(negedge clk);
    check("R1 y in reset", int'($signed(y)), 0);
    rst_n = 1'b1;

    // R7: zero input from reset
    for (int i = 0; i < 64; i++) begin
      step('0, 1'b1, "R7 zero input");
      check("R7 zero out", int'($signed(y)), 0);
    end

    // directed corners: smallest, largest, half
    do_reset();
    for (int i = 0; i < 200; i++) step(BW'(1), 1'b1, "R4 R2 x=1");
    do_reset();
    for (int i = 0; i < 200; i++) step({BW{1'b1}}, 1'b1, "R4 R5 x=max");
    do_reset();
    for (int i = 0; i < 200; i++) step(BW'(N/2), 1'b1, "R4 R5 x=half");

    // random input with random enable gaps; model resumes seamlessly
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic e;
      e  = ($urandom % 4) != 0;
      xv = BW'($urandom);
      if (!e) step(xv, 1'b0, "R6 disabled out");
      else    step(xv, 1'b1, "R4 R5 R6 random");
    end

    // R1: reset mid-run restarts from zero state
    do_reset();
    step(BW'(N/3), 1'b1, "R1 first after reset");
    step(BW'(N/3), 1'b1, "R1 second after reset");

    // R8: average over full period
    for (int v = 0; v < 4; v++) begin
      case (v)
        0: xv = BW'(1);
        1: xv = BW'(N/2 + 7);
        2: xv = {BW{1'b1}};
        default: xv = BW'($urandom);
      endcase
      do_reset();
      sum = 0;
      for (int i = 0; i < int'(N); i++) begin
        step(xv, 1'b1, "R4 avg run");
        sum += int'($signed(y));
      end
      n_chk++;
      if (sum < int'(xv) - 1 || sum > int'(xv) + 2) begin
        n_err++;
        $display("FAIL R8 sum: actual=%0d expected=%0d..%0d", sum, int'(xv) - 1, int'(xv) + 2);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule